// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one binary down-counter channel of a legacy interval timer. A bus interface elsewhere delivers a count value and an operating mode together with a one-cycle load strobe. From then on the channel counts timer ticks and drives a single output pin. A tick is any system-clock cycle on which the tick-enable input is high. The mode selects one of six output waveforms: interrupt on terminal count, retriggerable one-shot, rate generator, square wave, software-triggered strobe and hardware-triggered strobe. Mode codes 6 and 7 fold onto 2 and 3. A gate input either enables counting by its level or retriggers the count on its rising edge, depending on the mode.

The live count is always visible, so a neighbouring latch can capture it whenever it needs to. A loaded value of zero stands for the full range of the counter: 65536 with the default 16-bit width. In the square-wave mode the live count shows the ticks left in the current half period.

Top module: `pit_channel`

## Requirements
- R1: After a synchronous active-high reset the channel is in the square-wave mode with a count of 65536. It shows a live count of 0x8000 (the first half of the period) with the output high, and each tick lowers the count by one.
- R2: A loaded count of 0 acts as 65536. In mode 0 the live count reads 0, then 0xFFFF after one tick, and the output rises only after 65536 ticks.
- R3: The counter changes only on cycles where tick_en is 1, except on loads and retriggers. Cycles without a tick leave the count and the output unchanged.
- R4: Mode 0. The output is low from the load. It goes high when the number of ticks since the load equals the count N, and then stays high. The live count is (N−k) mod 65536 after k ticks.
- R5: Mode 1. After a load the count holds at N and the output stays high until the gate rises. A rising gate reloads N and drives the output low. The output goes high after N ticks and stays high, and a later rising edge retriggers. The gate level has no other effect.
- R6: Mode 2. The period is N ticks. The output is low for exactly the one tick during which the live count is 1, and the count then reloads to N. A gate low level halts counting and forces the output high. A rising gate reloads N.
- R7: Mode 3. The output is high for (N+1)/2 ticks and low for N/2 ticks, repeating. Each half counts down from its own length. A gate low level halts counting and forces the output high, and a rising gate restarts the high half.
- R8: Mode 4. The output is high from the load. It is low only during the tick span after exactly N ticks, then high again for good. The live count is (N−k) mod 65536.
- R9: Mode 5. Same waveform as mode 4, but counting starts only on a rising gate, which reloads N. Before the trigger the count holds and the output stays high.
- R10: In modes 0 and 4 a gate low level halts counting. A gate rising edge does not reload the count.
- R11: Mode codes 6 and 7 behave exactly like modes 2 and 3.
- R12: A load strobe takes priority over any gate edge or tick. It restarts the channel in the new mode on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timer tick qualifier; counting advances only when high |
| gate | input | 1 | Gate input (level enable or rising-edge trigger, by mode) |
| ld_stb | input | 1 | One-cycle strobe that loads mode and count |
| ld_mode | input | 3 | Operating mode code 0..7 |
| ld_count | input | 16 | Count value; 0 means 65536 |
| cnt_o | output | 16 | Live count (low 16 bits) |
| out_o | output | 1 | Channel output pin |

## Verification
Every mode code 0 to 7 is swept over counts 2 through 9. Each sample is compared with closed-form expressions for the output level and the live count as functions of the ticks elapsed. Odd and even counts separate the unequal square-wave halves from the equal ones. Codes 6 and 7 show that the mode aliasing folds onto the right waveform. The whole sweep is repeated with a tick on only every third cycle, which separates counting on ticks from counting on clocks. Directed gate sequences separate level-enable modes from edge-retrigger modes. A full 65536-tick run shows the zero-count expansion, and a mid-run reload shows that loading has priority.

// File: rtl/pit_pkg.sv
package pit_pkg;
   typedef enum logic [2:0] {
      M_TC_INT   = 3'd0,
      M_ONESHOT  = 3'd1,
      M_RATE     = 3'd2,
      M_SQUARE   = 3'd3,
      M_SW_STRB  = 3'd4,
      M_HW_STRB  = 3'd5
   } pit_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } pit_state_e;
endpackage

// File: rtl/pit_load_decode.sv
module pit_load_decode
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic [2:0]       raw_mode,
   input  logic [CNT_W-1:0] raw_count,
   output pit_mode_e        dec_mode,
   output logic [CNT_W:0]   dec_val
);
   localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pit_load_decode: CNT_W must be at least 2");
      end
   endgenerate

   always_comb begin
      if (raw_mode[2] && raw_mode[1]) dec_mode = pit_mode_e'({1'b0, raw_mode[1:0]});
      else                            dec_mode = pit_mode_e'(raw_mode);
   end

   assign dec_val = (raw_count == '0) ? FULL : {1'b0, raw_count};
endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge (
   input  logic clk,
   input  logic rst,
   input  logic gate,
   output logic rise
);
   logic gate_q;

   always_ff @(posedge clk) begin
      gate_q <= gate;
   end

   assign rise = gate && !gate_q && !rst;
endmodule

// File: rtl/pit_count_core.sv
module pit_count_core
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             gate,
   input  logic             gate_rise,
   input  logic             ld_stb,
   input  pit_mode_e        ld_mode,
   input  logic [CNT_W:0]   ld_val,
   output logic [CNT_W-1:0] cnt_lo,
   output logic             out_q
);
   localparam int          VW   = CNT_W + 1;
   localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
   localparam logic [CNT_W:0] HALF = {2'b01, {(CNT_W-1){1'b0}}};
   localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};
   localparam logic [CNT_W:0] TWO  = {{(CNT_W-1){1'b0}}, 2'b10};

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pit_count_core: CNT_W must be at least 2");
      end
   endgenerate

   function automatic logic [CNT_W:0] hi_half(input logic [CNT_W:0] v);
      logic [VW:0] s;
      s = {1'b0, v} + 1'b1;
      return s[VW:1];
   endfunction

   function automatic logic [CNT_W:0] lo_half(input logic [CNT_W:0] v);
      logic [CNT_W:0] h;
      h = v >> 1;
      return (h == '0) ? ONE : h;
   endfunction

   pit_mode_e      mode_q;
   pit_state_e     st_q;
   logic [CNT_W:0] val_q;
   logic [CNT_W:0] reload_q;
   logic [CNT_W:0] val_dec;
   logic [CNT_W:0] dec_raw;
   logic           retrig;
   logic           strobe_mode;
   logic           os_count;

   assign dec_raw     = val_q - 1'b1;
   assign val_dec     = {1'b0, dec_raw[CNT_W-1:0]};
   assign strobe_mode = (mode_q == M_SW_STRB) || (mode_q == M_HW_STRB);
   assign retrig      = gate_rise && ((mode_q == M_ONESHOT) || (mode_q == M_HW_STRB) ||
                                      (mode_q == M_RATE)    || (mode_q == M_SQUARE));
   assign os_count    = tick_en && (((mode_q == M_TC_INT) || (mode_q == M_SW_STRB)) ? gate
                                                                                   : (st_q != ST_IDLE));

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q   <= M_SQUARE;
         st_q     <= ST_RUN;
         reload_q <= FULL;
         val_q    <= HALF;
         out_q    <= 1'b1;
      end else if (ld_stb) begin
         mode_q   <= ld_mode;
         reload_q <= ld_val;
         val_q    <= (ld_mode == M_SQUARE) ? hi_half(ld_val) : ld_val;
         out_q    <= (ld_mode != M_TC_INT);
         st_q     <= ((ld_mode == M_ONESHOT) || (ld_mode == M_HW_STRB)) ? ST_IDLE : ST_RUN;
      end else if (retrig) begin
         val_q <= (mode_q == M_SQUARE) ? hi_half(reload_q) : reload_q;
         out_q <= (mode_q != M_ONESHOT);
         st_q  <= ST_RUN;
      end else begin
         case (mode_q)
            M_RATE: begin
               if (!gate) begin
                  out_q <= 1'b1;
               end else if (tick_en) begin
                  if (val_q == ONE) begin
                     val_q <= reload_q;
                     out_q <= 1'b1;
                  end else begin
                     val_q <= val_dec;
                     if (val_q == TWO) out_q <= 1'b0;
                  end
               end
            end
            M_SQUARE: begin
               if (!gate) begin
                  out_q <= 1'b1;
               end else if (tick_en) begin
                  if (val_q == ONE) begin
                     out_q <= !out_q;
                     val_q <= out_q ? lo_half(reload_q) : hi_half(reload_q);
                  end else begin
                     val_q <= val_dec;
                  end
               end
            end
            default: begin
               if (os_count) begin
                  val_q <= val_dec;
                  if (st_q == ST_RUN && val_q == ONE) begin
                     st_q  <= ST_DONE;
                     out_q <= !strobe_mode;
                  end else if (st_q == ST_DONE) begin
                     out_q <= 1'b1;
                  end
               end
            end
         endcase
      end
   end

   assign cnt_lo = val_q[CNT_W-1:0];

   p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (val_q == HALF) && out_q && (mode_q == M_SQUARE));

   p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
      (!tick_en && !ld_stb && !retrig) |=> $stable(val_q));

   p_tc_stays_high_r4: assert property (@(posedge clk) disable iff (rst)
      ((mode_q == M_TC_INT || mode_q == M_ONESHOT) && st_q == ST_DONE && !ld_stb && !retrig)
      |=> out_q);

   p_idle_holds_r5: assert property (@(posedge clk) disable iff (rst)
      (st_q == ST_IDLE && !ld_stb && !retrig) |=> ($stable(val_q) && out_q));

   p_rate_low_one_r6: assert property (@(posedge clk) disable iff (rst)
      (mode_q == M_RATE && !out_q && tick_en && gate && !ld_stb && !retrig) |=> out_q);

   p_strobe_one_r8: assert property (@(posedge clk) disable iff (rst)
      (strobe_mode && !out_q && os_count && !ld_stb && !retrig) |=> out_q);

   p_gate_halt_r10: assert property (@(posedge clk) disable iff (rst)
      ((mode_q == M_TC_INT || mode_q == M_SW_STRB) && !gate && !ld_stb) |=> $stable(val_q));
endmodule

// File: rtl/pit_channel.sv
module pit_channel
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             gate,
   input  logic             ld_stb,
   input  logic [2:0]       ld_mode,
   input  logic [CNT_W-1:0] ld_count,
   output logic [CNT_W-1:0] cnt_o,
   output logic             out_o
);
   pit_mode_e      dec_mode;
   logic [CNT_W:0] dec_val;
   logic           gate_rise;

   pit_load_decode #(.CNT_W(CNT_W)) i_decode (
      .raw_mode  (ld_mode),
      .raw_count (ld_count),
      .dec_mode  (dec_mode),
      .dec_val   (dec_val)
   );

   pit_gate_edge i_edge (
      .clk  (clk),
      .rst  (rst),
      .gate (gate),
      .rise (gate_rise)
   );

   pit_count_core #(.CNT_W(CNT_W)) i_core (
      .clk       (clk),
      .rst       (rst),
      .tick_en   (tick_en),
      .gate      (gate),
      .gate_rise (gate_rise),
      .ld_stb    (ld_stb),
      .ld_mode   (dec_mode),
      .ld_val    (dec_val),
      .cnt_lo    (cnt_o),
      .out_q     (out_o)
   );

   p_zero_load_r2: assert property (@(posedge clk) disable iff (rst)
      (ld_stb && ld_count == '0 && !(ld_mode[1] && ld_mode[0])) |=> (cnt_o == '0));

   p_load_first_r12: assert property (@(posedge clk) disable iff (rst)
      (ld_stb && ld_mode == 3'd0) |=> !out_o);
endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
   logic        clk = 1'b0;
   logic        rst;
   logic        tick_en;
   logic        gate;
   logic        ld_stb;
   logic [2:0]  ld_mode;
   logic [15:0] ld_count;
   logic [15:0] cnt_o;
   logic        out_o;

   int checks = 0;
   int errors = 0;
   bit summary_done = 1'b0;

   always #10 clk = !clk;

   pit_channel i_pit_channel (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (tick_en),
      .gate     (gate),
      .ld_stb   (ld_stb),
      .ld_mode  (ld_mode),
      .ld_count (ld_count),
      .cnt_o    (cnt_o),
      .out_o    (out_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!summary_done) begin
         summary_done = 1'b1;
         $display("  Result: errors=%0d of %0d checks", errors, checks);
      end
      $finish;
   endtask

   task automatic cyc(input logic te);
      tick_en = te;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input int m, input int n, input logic g);
      ld_stb   = 1'b1;
      ld_mode  = 3'(m);
      ld_count = 16'(n);
      gate     = g;
      tick_en  = 1'b0;
      @(posedge clk);
      @(negedge clk);
      ld_stb = 1'b0;
   endtask

   function automatic int exp_out(input int em, input int n, input int k);
      int p;
      case (em)
         0, 1: return (k >= n) ? 1 : 0;
         2:    return ((k % n) != n - 1) ? 1 : 0;
         3: begin
            p = k % n;
            return (p < (n + 1) / 2) ? 1 : 0;
         end
         default: return (k != n) ? 1 : 0;
      endcase
   endfunction

   function automatic int exp_cnt(input int em, input int n, input int k);
      int p;
      int h;
      case (em)
         2: return n - (k % n);
         3: begin
            p = k % n;
            h = (n + 1) / 2;
            return (p < h) ? (h - p) : ((n / 2) - (p - h));
         end
         default: return (n - k) & 16'hFFFF;
      endcase
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      rst = 1'b1; tick_en = 1'b0; gate = 1'b1; ld_stb = 1'b0; ld_mode = '0; ld_count = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk("R1 reset count", int'(cnt_o), 32'h8000);
      chk("R1 reset out", int'(out_o), 1);
      cyc(1'b1);
      chk("R1 first tick", int'(cnt_o), 32'h7FFF);

      // Sweep of every mode code, counts 2..9, two tick patterns (R3..R9, R11)
      for (int m = 0; m < 8; m++) begin
         for (int n = 2; n <= 9; n++) begin
            for (int pat = 0; pat < 2; pat++) begin
               int    em;
               int    k;
               string req;
               em = (m >= 6) ? m - 4 : m;
               case (em)
                  0: req = "R4"; 1: req = "R5"; 2: req = "R6";
                  3: req = "R7"; 4: req = "R8"; default: req = "R9";
               endcase
               if (m >= 6) req = "R11";
               if (pat == 1) req = {req, "/R3"};
               if (em == 1 || em == 5) begin
                  load(m, n, 1'b0);
                  chk({req, " idle out"}, int'(out_o), 1);
                  chk({req, " idle cnt"}, int'(cnt_o), n);
                  gate = 1'b1;
                  cyc(1'b1);
               end else begin
                  load(m, n, 1'b1);
               end
               k = 0;
               chk({req, " out"}, int'(out_o), exp_out(em, n, k));
               chk({req, " cnt"}, int'(cnt_o), exp_cnt(em, n, k));
               for (int s = 0; s < (3 * n + 3) * ((pat == 1) ? 3 : 1); s++) begin
                  logic te;
                  te = (pat == 1) ? ((s % 3) == 0) : 1'b1;
                  cyc(te);
                  if (te) k++;
                  chk({req, " out"}, int'(out_o), exp_out(em, n, k));
                  chk({req, " cnt"}, int'(cnt_o), exp_cnt(em, n, k));
               end
            end
         end
      end

      // R10: gate level halts mode 0, rising edge does not reload
      load(0, 5, 1'b1);
      cyc(1'b1); cyc(1'b1);
      gate = 1'b0;
      cyc(1'b1); cyc(1'b1); cyc(1'b1);
      chk("R10 mode0 halt cnt", int'(cnt_o), 3);
      chk("R10 mode0 halt out", int'(out_o), 0);
      gate = 1'b1;
      cyc(1'b1);
      chk("R10 mode0 no retrigger", int'(cnt_o), 2);
      load(4, 4, 1'b0);
      cyc(1'b1); cyc(1'b1);
      chk("R10 mode4 halt", int'(cnt_o), 4);
      gate = 1'b1;
      cyc(1'b1);
      chk("R10 mode4 no retrigger", int'(cnt_o), 3);

      // R6: gate low forces output high and halts, rising edge reloads
      load(2, 5, 1'b1);
      cyc(1'b1); cyc(1'b1); cyc(1'b1);
      chk("R6 before low", int'(out_o), 1);
      cyc(1'b1);
      chk("R6 low at one", int'(out_o), 0);
      gate = 1'b0;
      cyc(1'b1);
      chk("R6 gate low out", int'(out_o), 1);
      chk("R6 gate low cnt", int'(cnt_o), 1);
      gate = 1'b1;
      cyc(1'b1);
      chk("R6 retrigger cnt", int'(cnt_o), 5);
      cyc(1'b1);
      chk("R6 after retrigger", int'(cnt_o), 4);

      // R7: square wave gate control
      load(3, 6, 1'b1);
      repeat (4) cyc(1'b1);
      chk("R7 low half out", int'(out_o), 0);
      chk("R7 low half cnt", int'(cnt_o), 2);
      gate = 1'b0;
      cyc(1'b1);
      chk("R7 gate low out", int'(out_o), 1);
      chk("R7 gate low cnt", int'(cnt_o), 2);
      gate = 1'b1;
      cyc(1'b1);
      chk("R7 retrigger cnt", int'(cnt_o), 3);

      // R5: retrigger in mode 1, gate level otherwise ignored
      load(1, 4, 1'b0);
      gate = 1'b1;
      cyc(1'b1);
      chk("R5 trigger out", int'(out_o), 0);
      cyc(1'b1); cyc(1'b1);
      gate = 1'b0;
      cyc(1'b1);
      chk("R5 gate level ignored", int'(cnt_o), 1);
      gate = 1'b1;
      cyc(1'b1);
      chk("R5 retrigger cnt", int'(cnt_o), 4);
      chk("R5 retrigger out", int'(out_o), 0);

      // R12: load takes priority mid-run
      load(3, 10, 1'b1);
      cyc(1'b1); cyc(1'b1);
      ld_stb = 1'b1; ld_mode = 3'd0; ld_count = 16'd3; tick_en = 1'b1;
      @(posedge clk); @(negedge clk);
      ld_stb = 1'b0;
      chk("R12 new count", int'(cnt_o), 3);
      chk("R12 new out", int'(out_o), 0);

      // R2: zero count acts as 65536
      load(0, 0, 1'b1);
      chk("R2 zero cnt", int'(cnt_o), 0);
      cyc(1'b1);
      chk("R2 first tick", int'(cnt_o), 32'hFFFF);
      repeat (65534) cyc(1'b1);
      chk("R2 cnt before tc", int'(cnt_o), 1);
      chk("R2 out before tc", int'(out_o), 0);
      cyc(1'b1);
      chk("R2 out at tc", int'(out_o), 1);
      chk("R2 cnt at tc", int'(cnt_o), 0);

      finish_run();
   end
endmodule